// File: doc/BRIEF.md
# Front-Panel Console Register Datapath

This block holds the registers that sit behind the switches and lamps of a minicomputer operator panel. A 16-bit address-lamp register and an 8-bit data-lamp register each take their next value from either the entry switches or the matching system bus. A two-input multiplexer per register makes that choice, and an external load strobe commits it on the clock edge. The address-lamp register can also count one step up or down under an external step strobe and direction level, so an outside sequencer can walk through memory. A separate 16-bit start-address register captures the switches on its own strobe. The processor fetches it later as two bytes, each byte through its own output enable.

Bus outputs are tri-state in intent. Each bus is modelled as a data output plus an enable output, and the data output reads zero whenever the enable is low. Both lamp registers are also brought out continuously for the panel lamps. The data bus has three possible sources: the data-lamp register, the start-address low byte and the start-address high byte. A contention flag is raised combinationally whenever more than one of them is enabled in the same cycle. Every control strobe comes from an external sequencer, and this block makes no decisions of its own.

Top module: `console_regfile`

## Requirements
- R1: When `al_load` is high at a rising clock edge, the address-lamp register takes `abus_in` if `al_sel_bus` is 1, and `sw_in` if `al_sel_bus` is 0.
- R2: When `al_step` is high and `al_load` is low, the address-lamp register increments by one if `al_down` is 0 and decrements by one if `al_down` is 1. With neither strobe it holds its value.
- R3: Address counting wraps modulo 2^16: a step up from FFFFh gives 0000h, and a step down from 0000h gives FFFFh.
- R4: When `al_load` and `al_step` are both high in one cycle, the load is performed and the step is ignored.
- R5: `abus_oe` equals `al_drive`. While it is high, `abus_out` equals the address-lamp register; while it is low, `abus_out` is zero.
- R6: When `dl_load` is high, the data-lamp register takes `dbus_in` if `dl_sel_bus` is 1, and `sw_in[7:0]` if it is 0. It never counts, and without `dl_load` it holds its value even while the address strobes toggle.
- R7: When `sa_load` is high, the start-address register captures all 16 bits of `sw_in`. Otherwise it holds its value.
- R8: `sa_drive[0]` places start-address bits 7:0 on `dbus_out`, and `sa_drive[1]` places bits 15:8.
- R9: `lamp_addr` and `lamp_data` always show the two lamp registers, whatever the state of the bus enables.
- R10: `dbus_conflict` is 1 in exactly those cycles in which two or more of `dl_drive`, `sa_drive[0]` and `sa_drive[1]` are high.
- R11: After reset all three registers read zero, both bus enables are low and `dbus_conflict` is low.
- R12: `dbus_oe` is high when any data-bus source is enabled. `dl_drive` places the data-lamp register on `dbus_out` and takes priority over the start-address bytes. With no source enabled, `dbus_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_in | input | 16 | Entry switch levels |
| abus_in | input | 16 | Address bus value seen by the block |
| dbus_in | input | 8 | Data bus value seen by the block |
| al_sel_bus | input | 1 | Address-lamp source select: 1 selects the bus, 0 selects the switches |
| al_load | input | 1 | Address-lamp load strobe |
| al_step | input | 1 | Address-lamp step strobe |
| al_down | input | 1 | Step direction: 1 counts down, 0 counts up |
| al_drive | input | 1 | Drive the address-lamp register onto the address bus |
| dl_sel_bus | input | 1 | Data-lamp source select: 1 selects the bus, 0 selects the switches |
| dl_load | input | 1 | Data-lamp load strobe |
| dl_drive | input | 1 | Drive the data-lamp register onto the data bus |
| sa_load | input | 1 | Start-address load strobe |
| sa_drive | input | 2 | Start-address byte enables: bit 0 low byte, bit 1 high byte |
| abus_out | output | 16 | Address bus drive value |
| abus_oe | output | 1 | Address bus drive enable |
| dbus_out | output | 8 | Data bus drive value |
| dbus_oe | output | 1 | Data bus drive enable |
| lamp_addr | output | 16 | Address-lamp register contents |
| lamp_data | output | 8 | Data-lamp register contents |
| dbus_conflict | output | 1 | More than one data-bus source enabled |

## Verification
The bound checker watches every cycle for the following:
- the next value of each register after a load, a step or an idle cycle, including the wrap from all ones;
- load taking priority over step;
- the zero value on each bus while its enable is low;
- which byte of the start address, or the data-lamp register, reaches the data bus;
- the agreement between the contention flag and the number of enabled sources.

Only the bench's scenarios can show longer behaviour: that chained steps walk across both wrap boundaries in the right direction, that the values a register captures survive later operations on the other registers, and that the reset state is correct.

// File: rtl/console_pkg.sv
package console_pkg;
   localparam int unsigned CON_ADDR_W = 16;
   localparam int unsigned CON_DATA_W = 8;

   typedef enum logic {
      SRC_SWITCH = 1'b0,
      SRC_BUS    = 1'b1
   } src_sel_e;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_UP   = 2'd2,
      ACT_DOWN = 2'd3
   } cnt_act_e;

   function automatic cnt_act_e decode_act(input logic load, input logic step, input logic down);
      if (load)      return ACT_LOAD;
      else if (step) return down ? ACT_DOWN : ACT_UP;
      else           return ACT_HOLD;
   endfunction
endpackage

// File: rtl/con_addr_reg.sv
module con_addr_reg
   import console_pkg::*;
#(
   parameter int unsigned W = CON_ADDR_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sw_val,
   input  logic [W-1:0] bus_val,
   input  logic         sel_bus,
   input  logic         load,
   input  logic         step,
   input  logic         down,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] mux_val;
   cnt_act_e     act;

   assign mux_val = (src_sel_e'(sel_bus) == SRC_BUS) ? bus_val : sw_val;
   assign act     = decode_act(load, step, down);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         unique case (act)
            ACT_LOAD: q <= mux_val;
            ACT_UP:   q <= q + ONE;
            ACT_DOWN: q <= q - ONE;
            default:  q <= q;
         endcase
      end
   end
endmodule

// File: rtl/con_data_reg.sv
module con_data_reg
   import console_pkg::*;
#(
   parameter int unsigned W = CON_DATA_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sw_val,
   input  logic [W-1:0] bus_val,
   input  logic         sel_bus,
   input  logic         load,
   output logic [W-1:0] q
);
   logic [W-1:0] mux_val;

   assign mux_val = (src_sel_e'(sel_bus) == SRC_BUS) ? bus_val : sw_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= mux_val;
   end
endmodule

// File: rtl/con_start_reg.sv
module con_start_reg #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        sw_val,
   input  logic                 load,
   output logic [AW-1:0]        q,
   output logic [AW-1:0]        bytes_flat
);
   localparam int unsigned NB = AW / DW;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= sw_val;
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign bytes_flat[b*DW +: DW] = q[b*DW +: DW];
   end
endmodule

// File: rtl/con_dbus_merge.sv
module con_dbus_merge #(
   parameter int unsigned DW   = 8,
   parameter int unsigned NSRC = 3
) (
   input  logic [NSRC*DW-1:0] src_flat,
   input  logic [NSRC-1:0]    src_en,
   output logic [DW-1:0]      bus_val,
   output logic               bus_en,
   output logic               clash
);
   localparam int unsigned CW = $clog2(NSRC + 1);

   logic [CW-1:0] n_en;

   always_comb begin
      bus_val = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (src_en[i]) bus_val = src_flat[i*DW +: DW];
      end
   end

   always_comb begin
      n_en = '0;
      for (int i = 0; i < NSRC; i++) n_en = n_en + CW'(src_en[i]);
   end

   assign bus_en = |src_en;
   assign clash  = (n_en > CW'(1));
endmodule

// File: rtl/console_regfile.sv
module console_regfile
   import console_pkg::*;
#(
   parameter int unsigned ADDR_W = CON_ADDR_W,
   parameter int unsigned DATA_W = CON_DATA_W,
   localparam int unsigned SA_BYTES = ADDR_W / DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   sw_in,
   input  logic [ADDR_W-1:0]   abus_in,
   input  logic [DATA_W-1:0]   dbus_in,
   input  logic                al_sel_bus,
   input  logic                al_load,
   input  logic                al_step,
   input  logic                al_down,
   input  logic                al_drive,
   input  logic                dl_sel_bus,
   input  logic                dl_load,
   input  logic                dl_drive,
   input  logic                sa_load,
   input  logic [SA_BYTES-1:0] sa_drive,
   output logic [ADDR_W-1:0]   abus_out,
   output logic                abus_oe,
   output logic [DATA_W-1:0]   dbus_out,
   output logic                dbus_oe,
   output logic [ADDR_W-1:0]   lamp_addr,
   output logic [DATA_W-1:0]   lamp_data,
   output logic                dbus_conflict
);
   localparam int unsigned NSRC = SA_BYTES + 1;

   if (DATA_W == 0 || ADDR_W % DATA_W != 0) begin : g_bad_ratio
      $error("console_regfile: ADDR_W must be a whole multiple of DATA_W");
   end
   if (SA_BYTES < 2) begin : g_bad_bytes
      $error("console_regfile: start address must span at least two bytes");
   end

   logic [ADDR_W-1:0]      sa_value;
   logic [ADDR_W-1:0]      sa_bytes;
   logic [NSRC*DATA_W-1:0] src_flat;
   logic [NSRC-1:0]        src_en;

   con_addr_reg #(.W(ADDR_W)) i_addr (
      .clk(clk), .rst_n(rst_n), .sw_val(sw_in), .bus_val(abus_in),
      .sel_bus(al_sel_bus), .load(al_load), .step(al_step), .down(al_down),
      .q(lamp_addr)
   );

   con_data_reg #(.W(DATA_W)) i_data (
      .clk(clk), .rst_n(rst_n), .sw_val(sw_in[DATA_W-1:0]), .bus_val(dbus_in),
      .sel_bus(dl_sel_bus), .load(dl_load), .q(lamp_data)
   );

   con_start_reg #(.AW(ADDR_W), .DW(DATA_W)) i_start (
      .clk(clk), .rst_n(rst_n), .sw_val(sw_in), .load(sa_load),
      .q(sa_value), .bytes_flat(sa_bytes)
   );

   assign src_flat = {sa_bytes, lamp_data};
   assign src_en   = {sa_drive, dl_drive};

   con_dbus_merge #(.DW(DATA_W), .NSRC(NSRC)) i_merge (
      .src_flat(src_flat), .src_en(src_en),
      .bus_val(dbus_out), .bus_en(dbus_oe), .clash(dbus_conflict)
   );

   assign abus_oe  = al_drive;
   assign abus_out = al_drive ? lamp_addr : '0;
endmodule

// File: rtl/console_regfile_chk.sv
module console_regfile_chk #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8,
   parameter int unsigned NB = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] sw_in,
   input logic [AW-1:0] abus_in,
   input logic [DW-1:0] dbus_in,
   input logic          al_sel_bus,
   input logic          al_load,
   input logic          al_step,
   input logic          al_down,
   input logic          al_drive,
   input logic          dl_sel_bus,
   input logic          dl_load,
   input logic          dl_drive,
   input logic          sa_load,
   input logic [NB-1:0] sa_drive,
   input logic [AW-1:0] abus_out,
   input logic          abus_oe,
   input logic [DW-1:0] dbus_out,
   input logic          dbus_oe,
   input logic [AW-1:0] lamp_addr,
   input logic [DW-1:0] lamp_data,
   input logic          dbus_conflict,
   input logic [AW-1:0] sa_value
);
   assert_addr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      al_load |=> lamp_addr == ($past(al_sel_bus) ? $past(abus_in) : $past(sw_in)));

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!al_load && al_step) |=> lamp_addr ==
         ($past(al_down) ? $past(lamp_addr) - AW'(1) : $past(lamp_addr) + AW'(1)));

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!al_load && !al_step) |=> $stable(lamp_addr));

   assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!al_load && al_step && !al_down && lamp_addr == '1) |=> lamp_addr == '0);

   assert_wrap_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!al_load && al_step && al_down && lamp_addr == '0) |=> lamp_addr == '1);

   assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (al_load && al_step && !al_sel_bus) |=> lamp_addr == $past(sw_in));

   assert_abus_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      abus_oe == al_drive);

   assert_abus_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !abus_oe |-> abus_out == '0);

   assert_abus_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      abus_oe |-> abus_out == lamp_addr);

   assert_data_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dl_load |=> lamp_data == ($past(dl_sel_bus) ? $past(dbus_in) : $past(sw_in[DW-1:0])));

   assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !dl_load |=> $stable(lamp_data));

   assert_start_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sa_load |=> sa_value == $past(sw_in));

   assert_start_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sa_load |=> $stable(sa_value));

   assert_start_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dl_drive && sa_drive == NB'(1)) |-> dbus_out == sa_value[DW-1:0]);

   assert_start_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dl_drive && sa_drive == NB'(1) << (NB - 1)) |-> dbus_out == sa_value[AW-1 -: DW]);

   assert_conflict_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({dl_drive, sa_drive}) > 1) |-> dbus_conflict);

   assert_conflict_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones({dl_drive, sa_drive}) <= 1) |-> !dbus_conflict);

   assert_dbus_lamp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      dl_drive |-> (dbus_oe && dbus_out == lamp_data));

   assert_dbus_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !dbus_oe |-> dbus_out == '0);
endmodule

bind console_regfile console_regfile_chk #(
   .AW(ADDR_W), .DW(DATA_W), .NB(SA_BYTES)
) i_chk (
   .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .abus_in(abus_in), .dbus_in(dbus_in),
   .al_sel_bus(al_sel_bus), .al_load(al_load), .al_step(al_step), .al_down(al_down),
   .al_drive(al_drive), .dl_sel_bus(dl_sel_bus), .dl_load(dl_load), .dl_drive(dl_drive),
   .sa_load(sa_load), .sa_drive(sa_drive), .abus_out(abus_out), .abus_oe(abus_oe),
   .dbus_out(dbus_out), .dbus_oe(dbus_oe), .lamp_addr(lamp_addr), .lamp_data(lamp_data),
   .dbus_conflict(dbus_conflict), .sa_value(sa_value)
);

// File: tb/test_console_regfile.sv
module test_console_regfile;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sw_in = '0, abus_in = '0;
   logic [7:0]  dbus_in = '0;
   logic        al_sel_bus = 0, al_load = 0, al_step = 0, al_down = 0, al_drive = 0;
   logic        dl_sel_bus = 0, dl_load = 0, dl_drive = 0, sa_load = 0;
   logic [1:0]  sa_drive = '0;
   logic [15:0] abus_out, lamp_addr;
   logic [7:0]  dbus_out, lamp_data;
   logic        abus_oe, dbus_oe, dbus_conflict;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   console_regfile i_console_regfile (
      .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .abus_in(abus_in), .dbus_in(dbus_in),
      .al_sel_bus(al_sel_bus), .al_load(al_load), .al_step(al_step), .al_down(al_down),
      .al_drive(al_drive), .dl_sel_bus(dl_sel_bus), .dl_load(dl_load), .dl_drive(dl_drive),
      .sa_load(sa_load), .sa_drive(sa_drive), .abus_out(abus_out), .abus_oe(abus_oe),
      .dbus_out(dbus_out), .dbus_oe(dbus_oe), .lamp_addr(lamp_addr), .lamp_data(lamp_data),
      .dbus_conflict(dbus_conflict)
   );

   typedef struct packed {
      logic        a_sel, a_ld, a_st, a_dn, d_sel, d_ld;
      logic [15:0] sw, ab;
      logic [7:0]  db;
      logic [15:0] exp_a;
      logic [7:0]  exp_d;
   } vec_t;

   // R1, R2, R4, R6: register updates, checked one clock after each vector
   localparam vec_t VECS [8] = '{
      '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h1234, 16'h9999, 8'h00, 16'h1234, 8'h00}, // R1 switches
      '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h1111, 16'hABCD, 8'h00, 16'hABCD, 8'h00}, // R1 bus
      '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 16'h0000, 16'h0000, 8'h00, 16'hABCE, 8'h00}, // R2 up, R6 no count
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 16'h0000, 16'h0000, 8'h00, 16'hABCD, 8'h00}, // R2 down
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 16'h5A77, 16'h0000, 8'hEE, 16'hABCD, 8'h77}, // R6 switches
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h5A77, 16'h0000, 8'hC3, 16'hABCD, 8'hC3}, // R6 bus
      '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0FFF, 16'h2222, 8'h00, 16'h0FFF, 8'hC3}, // R4 load wins
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h7777, 16'h3333, 8'h44, 16'h0FFF, 8'hC3}  // R2 hold, R6 hold
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      al_load = 0; al_step = 0; al_down = 0; al_sel_bus = 0;
      dl_load = 0; dl_sel_bus = 0; sa_load = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 lamp_addr", 32'(lamp_addr), 0);
      chk("R11 lamp_data", 32'(lamp_data), 0);
      chk("R11 enables/conflict", {29'd0, abus_oe, dbus_oe, dbus_conflict}, 0);
      rst_n = 1;
      tick();

      foreach (VECS[i]) begin
         al_sel_bus = VECS[i].a_sel; al_load = VECS[i].a_ld;
         al_step = VECS[i].a_st;     al_down = VECS[i].a_dn;
         dl_sel_bus = VECS[i].d_sel; dl_load = VECS[i].d_ld;
         sw_in = VECS[i].sw; abus_in = VECS[i].ab; dbus_in = VECS[i].db;
         tick();
         chk($sformatf("R1/R2/R4 vec%0d lamp_addr", i), 32'(lamp_addr), 32'(VECS[i].exp_a));
         chk($sformatf("R6 vec%0d lamp_data", i), 32'(lamp_data), 32'(VECS[i].exp_d));
      end
      idle();

      // R3 wrap up and down
      sw_in = 16'hFFFF; al_load = 1; tick();
      al_load = 0; al_step = 1; tick();
      chk("R3 wrap up", 32'(lamp_addr), 32'h0000);
      al_down = 1; tick();
      chk("R3 wrap down", 32'(lamp_addr), 32'hFFFF);
      al_down = 1; tick();
      chk("R3 step after wrap", 32'(lamp_addr), 32'hFFFE);
      idle();

      // R5 address bus drive
      #1;
      chk("R5 bus idle", {15'd0, abus_oe, abus_out}, 0);
      al_drive = 1; #1;
      chk("R5 bus driven", {15'd0, abus_oe, abus_out}, {15'd0, 1'b1, 16'hFFFE});
      chk("R9 lamp with drive", 32'(lamp_addr), 32'hFFFE);
      al_drive = 0; tick();

      // R7 start address load, other registers untouched
      sw_in = 16'hBEEF; sa_load = 1; tick();
      sa_load = 0; sw_in = 16'h0000; tick();
      chk("R7 lamp_addr untouched", 32'(lamp_addr), 32'hFFFE);

      // R8 byte readout
      sa_drive = 2'b01; #1;
      chk("R8 low byte", {23'd0, dbus_oe, dbus_out}, {23'd0, 1'b1, 8'hEF});
      sa_drive = 2'b10; #1;
      chk("R8 high byte", {23'd0, dbus_oe, dbus_out}, {23'd0, 1'b1, 8'hBE});
      chk("R10 single source", 32'(dbus_conflict), 0);
      sa_drive = 2'b11; #1;
      chk("R10 two start bytes", 32'(dbus_conflict), 1);

      // R12 data lamp drive and priority
      sa_drive = 2'b00; dl_drive = 1; #1;
      chk("R12 lamp on bus", {23'd0, dbus_oe, dbus_out}, {23'd0, 1'b1, 8'hC3});
      chk("R10 lamp alone", 32'(dbus_conflict), 0);
      sa_drive = 2'b01; #1;
      chk("R12 priority", 32'(dbus_out), 32'hC3);
      chk("R10 lamp plus byte", 32'(dbus_conflict), 1);
      dl_drive = 0; sa_drive = 2'b00; #1;
      chk("R12 bus idle", {23'd0, dbus_oe, dbus_out}, 0);
      chk("R9 lamp_data idle", 32'(lamp_data), 32'hC3);

      // R7 hold: reload start later shows new value only after strobe
      sw_in = 16'h1357; tick();
      sa_drive = 2'b01; #1;
      chk("R7 hold without strobe", 32'(dbus_out), 32'hEF);
      sa_drive = 2'b00;
      sa_load = 1; tick(); sa_load = 0;
      sa_drive = 2'b10; #1;
      chk("R7 reload high", 32'(dbus_out), 32'h13);
      sa_drive = 2'b00;

      // R11 reset again clears everything
      tick();
      rst_n = 0; #1;
      chk("R11 async clear addr", 32'(lamp_addr), 0);
      sa_drive = 2'b11; #1;
      chk("R11 start cleared", 32'(dbus_out), 0);
      sa_drive = 2'b00;
      tick();
      rst_n = 1;
      tick();
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule